// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares two single-cycle pulse streams. The first is a reference stream that comes from a reference divider. The second is a variable stream that comes from a feedback divider. The block reports which stream is ahead in frequency or in phase. It also reports whether the loop is locked.

It gives this information in three forms:
- a pair of active-low error lines, one per input, which later logic can combine;
- one single-ended error line that can float, modelled as a data bit plus an output enable;
- a lock flag that is normally high and drops while the inputs disagree.

Inside the block there are two edge flags, one per input. A pulse sets its own flag. When both flags are set together, both clear on the next clock. When the inputs match, the result is a one-clock low pulse on both error lines at once, and no other activity. The loop filter and the charge pump sit outside the block.

Top module: `phase_freq_detector`

## Requirements
- R1: During and directly after reset, `err_ref_n` and `err_var_n` are 1, `se_oe` is 0, `se_data` is 0 and `lock_ok` is 1.
- R2: A `ref_pulse` sampled at a clock edge drives `err_ref_n` to 0 from that edge onward. It stays 0 until the clock after the edge that sets the variable-side flag.
- R3: A `var_pulse` sampled at a clock edge drives `err_var_n` to 0 from that edge onward. It stays 0 until the clock after the edge that sets the reference-side flag.
- R4: When `ref_pulse` and `var_pulse` arrive at the same edge, both error lines are 0 for exactly one clock and then return to 1.
- R5: When both error lines are 0, the next edge clears both. An exception applies at that same edge: a pulse present then re-arms its own flag.
- R6: While only `err_var_n` is 0 (variable stream fast or leading), `se_oe` is 1 and `se_data` is 0. While only `err_ref_n` is 0 (variable stream slow or lagging), `se_oe` is 1 and `se_data` is 1.
- R7: While neither error line is 0, or both are 0, `se_oe` is 0 (high impedance) and `se_data` is 0.
- R8: `lock_ok` is 0 in exactly the cycles where one error line is 0 and the other is 1. Otherwise it is 1.
- R9: Further pulses on an input whose flag is already set, while the other flag is clear, have no effect. The outputs stay the same as they would be without those pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One-clock pulse from the reference divider |
| var_pulse | input | 1 | One-clock pulse from the feedback divider |
| err_ref_n | output | 1 | Active-low error, asserted while the reference is ahead |
| err_var_n | output | 1 | Active-low error, asserted while the variable stream is ahead |
| se_data | output | 1 | Single-ended error level, 1 for reference ahead, 0 for variable ahead |
| se_oe | output | 1 | Output enable of the single-ended error; 0 means high impedance |
| lock_ok | output | 1 | Lock flag, 1 when the inputs agree |

## Verification
On every cycle the assertions check four properties:
- each pulse sets its own error line at the following edge;
- a set flag holds while the other input stays quiet;
- the state with both lines low never lasts longer than one clock unless both pulses arrive again;
- the lock flag is always the inverse of the single-ended enable.

The sign of the single-ended output, and the exact widths of the error pulses for a given lead, can only be shown by the bench scenarios. The same holds for the reset values and for the re-arm of a flag in its clearing cycle. The bench compares these against its own cycle model, using both directed cases and random pulse trains.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int unsigned PFD_NUM_CH = 2;
  localparam int unsigned PFD_CH_REF = 0;
  localparam int unsigned PFD_CH_VAR = 1;

  typedef struct packed {
    logic oe;
    logic data;
  } pfd_se_t;

  // Next value of one edge flag: a pending joint clear drops old state,
  // a pulse always sets the flag.
  function automatic logic pfd_flag_next(input logic cur, input logic clr, input logic pulse);
    return pulse | (cur & ~clr);
  endfunction

  // Drive of the single-ended error from the two flags.
  function automatic pfd_se_t pfd_se_drive(input logic ref_q, input logic var_q);
    pfd_se_t r;
    r.oe   = ref_q ^ var_q;
    r.data = ref_q & ~var_q;
    return r;
  endfunction

  // Lock indication from the two flags.
  function automatic logic pfd_in_lock(input logic ref_q, input logic var_q);
    return ~(ref_q ^ var_q);
  endfunction

endpackage

// File: rtl/pfd_edge_flag.sv
module pfd_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_req,
  output logic flag_q
);
  import pfd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= pfd_flag_next(flag_q, clr_req, set_pulse);
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> flag_q);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);

endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage (
  input  logic ref_q,
  input  logic var_q,
  output logic err_ref_n,
  output logic err_var_n,
  output logic se_data,
  output logic se_oe
);
  import pfd_pkg::*;

  pfd_se_t se;

  always_comb begin
    se        = pfd_se_drive(ref_q, var_q);
    err_ref_n = ~ref_q;
    err_var_n = ~var_q;
    se_data   = se.data;
    se_oe     = se.oe;
  end

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon (
  input  logic ref_q,
  input  logic var_q,
  output logic lock_ok
);
  import pfd_pkg::*;

  always_comb lock_ok = pfd_in_lock(ref_q, var_q);

endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic var_pulse,
  output logic err_ref_n,
  output logic err_var_n,
  output logic se_data,
  output logic se_oe,
  output logic lock_ok
);
  import pfd_pkg::*;

  logic [PFD_NUM_CH-1:0] pulse_in;
  logic [PFD_NUM_CH-1:0] flag_q;
  logic                  clr_both;

  assign pulse_in[PFD_CH_REF] = ref_pulse;
  assign pulse_in[PFD_CH_VAR] = var_pulse;

  // Both flags set: release both at the next edge.
  assign clr_both = &flag_q;

  for (genvar ch = 0; ch < PFD_NUM_CH; ch++) begin : g_flag
    pfd_edge_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (pulse_in[ch]),
      .clr_req   (clr_both),
      .flag_q    (flag_q[ch])
    );
  end

  pfd_out_stage u_out (
    .ref_q     (flag_q[PFD_CH_REF]),
    .var_q     (flag_q[PFD_CH_VAR]),
    .err_ref_n (err_ref_n),
    .err_var_n (err_var_n),
    .se_data   (se_data),
    .se_oe     (se_oe)
  );

  pfd_lock_mon u_lock (
    .ref_q   (flag_q[PFD_CH_REF]),
    .var_q   (flag_q[PFD_CH_VAR]),
    .lock_ok (lock_ok)
  );

  // Joint-low state lasts one clock unless both pulses arrive again.
  p_joint_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_ref_n && !err_var_n && !(ref_pulse && var_pulse)) |=> !(!err_ref_n && !err_var_n));

  p_var_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    var_pulse |=> !err_var_n);

  // Lock monitor and output stage must agree.
  p_lock_vs_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok == !se_oe);

endmodule

// File: tb/phase_freq_detector_test.sv
`timescale 1ns/1ps
module phase_freq_detector_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0;
  logic var_pulse = 1'b0;
  logic err_ref_n, err_var_n, se_data, se_oe, lock_ok;

  int checks = 0;
  int fails  = 0;
  bit mr = 1'b0;
  bit mv = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phase_freq_detector uut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .var_pulse(var_pulse),
    .err_ref_n(err_ref_n), .err_var_n(err_var_n),
    .se_data(se_data), .se_oe(se_oe), .lock_ok(lock_ok)
  );

  // Expected port vector {err_ref_n, err_var_n, se_oe, se_data, lock_ok}
  function automatic logic [4:0] expect_vec(input bit r, input bit v);
    logic [4:0] e;
    e[4] = !r;
    e[3] = !v;
    if (r && !v)      e[2:0] = 3'b110;
    else if (v && !r) e[2:0] = 3'b100;
    else              e[2:0] = 3'b001;
    return e;
  endfunction

  task automatic chk(input string req, input logic [4:0] exp_v);
    logic [4:0] act;
    act = {err_ref_n, err_var_n, se_oe, se_data, lock_ok};
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp_v);
    end
  endtask

  // Drive one cycle of pulses, advance bench model, check after the edge.
  task automatic step(input bit r, input bit v, input string req);
    bit joint;
    @(negedge clk);
    ref_pulse = r;
    var_pulse = v;
    @(posedge clk);
    joint = mr && mv;
    mr = joint ? r : (mr || r);
    mv = joint ? v : (mv || v);
    #1;
    chk(req, expect_vec(mr, mv));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    bit r, v;
    seed = 32'd7;
    void'($urandom(seed));
    #1;
    chk("R1", 5'b11001);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 5'b11001);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, "R1");
    chk("R1", 5'b11001);

    // Reference leads by three edges
    step(1, 0, "R2");
    chk("R6", 5'b01110);
    step(0, 0, "R2");
    step(0, 0, "R8");
    chk("R8", 5'b01110);
    step(0, 1, "R5");
    chk("R7", 5'b00001);
    step(0, 0, "R5");
    chk("R5", 5'b11001);

    // Variable leads
    step(0, 1, "R3");
    chk("R6", 5'b10100);
    step(0, 0, "R3");
    step(1, 0, "R3");
    step(0, 0, "R3");
    chk("R3", 5'b11001);

    // Coincident edges
    step(1, 1, "R4");
    chk("R4", 5'b00001);
    step(0, 0, "R4");
    chk("R4", 5'b11001);

    // Re-arm in clearing cycle
    step(1, 1, "R5");
    step(1, 0, "R5");
    chk("R5", 5'b01110);
    step(0, 1, "R5");
    step(0, 0, "R5");

    // Extra pulses on a set flag are absorbed
    step(0, 1, "R9");
    step(0, 1, "R9");
    step(0, 1, "R9");
    chk("R9", 5'b10100);
    step(1, 0, "R9");
    chk("R9", 5'b00001);
    step(0, 0, "R9");
    chk("R9", 5'b11001);

    // Random pulse trains
    for (int i = 0; i < 3000; i++) begin
      r = ($urandom % 4) == 0;
      v = ($urandom % ((i / 500) % 3 + 3)) == 0;
      step(r, v, "R8");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule